// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel

This block is one DMA channel that copies data between memory-mapped addresses. A small table of transfer records controls each copy. Each record gives a source address, a destination address, a byte count, per-side address stepping, an optional byte-order reversal, an optional completion interrupt and a link to the record that comes next. Software fills the table through a write-only register port. It then names the first record of a chain and leaves the rest to the hardware.

A pulse on the trigger input starts the channel. The channel then walks the chain one record at a time. For every element it makes one granted read and then one granted write on a simple request/grant memory master. When a record is flagged as the last one, the channel returns to idle. When the source step is turned off, one fixed data register, such as a converter output, can feed several separate buffers. The data then moves to the next buffer with no processor help.

Top module: `dmac_chain_engine`

## Requirements
- R1: After reset the channel is idle. `busy`, `mem_req`, `irq_pulse` and `irq_status` are all low.
- R2: A high `trig` while idle starts the channel on the record named by the start-pointer register, and any table index is allowed there. A `trig` while `busy` is high has no effect.
- R3: Without swap, each element is one byte. The channel makes one read and then one write, both with `mem_word` low and the data in bits 7:0. An address whose step flag is set advances by 1 after each element. An address whose flag is clear stays fixed.
- R4: When a record completes and its last flag (control bit 20) is clear, the channel loads the record whose index is in control bits 27:24. When the last flag is set, the channel returns to idle.
- R5: With control bit 18 set, elements are 32-bit words (`mem_word` high). The read is little-endian, its four bytes are reversed before the write, and the addresses step by 4. The byte count is rounded down to a multiple of 4.
- R6: Each completed record with control bit 19 set gives exactly one one-cycle `irq_pulse`, after its last write. A record with bit 19 clear gives none.
- R7: `irq_status` becomes 1 with every pulse and stays 1 until a write to channel word 1. A pulse in the same cycle as that write wins over the clear.
- R8: A record whose effective count is 0 makes no memory access. It still completes, with its interrupt and its link handled as in R4 and R6.
- R9: While `mem_req` is high and `mem_gnt` is low, the request, direction, size, address and write data all hold their values.
- R10: Register map. When `cfg_addr[6]` is 0, bits 5:2 select the record and bits 1:0 select the word: 0 is the source, 1 the destination, 2 the control. In the control word the count is bits 15:0, source step is bit 16 and destination step is bit 17. When `cfg_addr[6]` is 1, word 0 is the start pointer and word 1 clears the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 7 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| trig | input | 1 | Start request |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_word | output | 1 | 1 = 32-bit access, 0 = byte access |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Access accepted this cycle |
| mem_rdata | input | 32 | Read data, valid with the grant |
| busy | output | 1 | Channel is working on a chain |
| irq_pulse | output | 1 | One-cycle completion pulse |
| irq_status | output | 1 | Sticky completion flag |

## Verification
The main function is tried with four patterns:
- A plain byte copy with both addresses stepping.
- A swapped word copy whose count is not a multiple of 4. It shows whether the byte reversal is done and whether the count is rounded down, because the byte after the last whole word must stay untouched.
- A four-record fan-out from a fixed source whose value counts up on every read. It shows whether the source holds still, whether the chain moves on, and whether only the flagged records interrupt.
- A zero-count record linked to a copy with a fixed destination. It shows that an empty record still completes and links, and that a fixed destination keeps only the last byte.

The grant is random throughout, so holding the request steady and the read-then-write order are tested under stalls. A second trigger sent while busy must produce no extra writes.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
   localparam int CNT_W      = 16;
   localparam int LINK_W     = 4;
   localparam int CTL_SINC   = 16;
   localparam int CTL_DINC   = 17;
   localparam int CTL_SWAP   = 18;
   localparam int CTL_IRQ    = 19;
   localparam int CTL_LAST   = 20;
   localparam int CTL_LINK   = 24;

   typedef enum logic [2:0] {
      ST_IDLE, ST_LOAD_DESC, ST_READ, ST_WRITE, ST_NEXT, ST_DONE
   } chan_state_e;

   typedef struct packed {
      logic [LINK_W-1:0] link;
      logic              last;
      logic              irq_en;
      logic              swap;
      logic              dst_inc;
      logic              src_inc;
      logic [CNT_W-1:0]  count;
   } desc_ctl_t;

   function automatic desc_ctl_t unpack_ctl(input logic [31:0] w);
      desc_ctl_t c;
      c.count   = w[CNT_W-1:0];
      c.src_inc = w[CTL_SINC];
      c.dst_inc = w[CTL_DINC];
      c.swap    = w[CTL_SWAP];
      c.irq_en  = w[CTL_IRQ];
      c.last    = w[CTL_LAST];
      c.link    = w[CTL_LINK +: LINK_W];
      return c;
   endfunction
endpackage

// File: rtl/dmac_desc_table.sv
module dmac_desc_table
   import dmac_pkg::*;
#(
   parameter int NDESC = 16,
   parameter int AW    = 16,
   localparam int PTR_W = $clog2(NDESC)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [PTR_W-1:0] wr_idx,
   input  logic [1:0]       wr_word,
   input  logic [31:0]      wr_data,
   input  logic [PTR_W-1:0] rd_idx,
   output logic [AW-1:0]    rd_src,
   output logic [AW-1:0]    rd_dst,
   output desc_ctl_t        rd_ctl
);
   logic [AW-1:0] src_arr [NDESC];
   logic [AW-1:0] dst_arr [NDESC];
   desc_ctl_t     ctl_arr [NDESC];
   wire           unused_wdata = ^wr_data;

   for (genvar e = 0; e < NDESC; e++) begin : g_entry
      logic hit;
      assign hit = wr_en && (wr_idx == PTR_W'(e));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            src_arr[e] <= '0;
            dst_arr[e] <= '0;
            ctl_arr[e] <= '0;
         end else if (hit) begin
            case (wr_word)
               2'd0:    src_arr[e] <= wr_data[AW-1:0];
               2'd1:    dst_arr[e] <= wr_data[AW-1:0];
               2'd2:    ctl_arr[e] <= unpack_ctl(wr_data);
               default: ;
            endcase
         end
      end
   end

   assign rd_src = src_arr[rd_idx];
   assign rd_dst = dst_arr[rd_idx];
   assign rd_ctl = ctl_arr[rd_idx];
endmodule

// File: rtl/dmac_byte_order.sv
module dmac_byte_order #(
   parameter int DW = 32,
   localparam int NB = DW / 8
) (
   input  logic          swap,
   input  logic [DW-1:0] din,
   output logic [DW-1:0] dout
);
   logic [DW-1:0] rev;

   for (genvar b = 0; b < NB; b++) begin : g_lane
      assign rev[8*b +: 8] = din[DW-8*(b+1) +: 8];
   end

   assign dout = swap ? rev : {{(DW-8){1'b0}}, din[7:0]};
endmodule

// File: rtl/dmac_addr_step.sv
module dmac_addr_step #(
   parameter int AW = 16
) (
   input  logic [AW-1:0] addr,
   input  logic          inc,
   input  logic          wide,
   output logic [AW-1:0] next
);
   logic [AW-1:0] step;
   assign step = wide ? AW'(4) : AW'(1);
   assign next = inc ? addr + step : addr;
endmodule

// File: rtl/dmac_chain_engine.sv
module dmac_chain_engine
   import dmac_pkg::*;
#(
   parameter int NDESC = 16,
   parameter int AW    = 16,
   localparam int PTR_W = $clog2(NDESC),
   localparam int CA_W  = PTR_W + 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cfg_we,
   input  logic [CA_W-1:0] cfg_addr,
   input  logic [31:0]     cfg_wdata,
   input  logic            trig,
   output logic            mem_req,
   output logic            mem_we,
   output logic            mem_word,
   output logic [AW-1:0]   mem_addr,
   output logic [31:0]     mem_wdata,
   input  logic            mem_gnt,
   input  logic [31:0]     mem_rdata,
   output logic            busy,
   output logic            irq_pulse,
   output logic            irq_status
);
   if (NDESC < 2 || NDESC > (1 << LINK_W) || (1 << PTR_W) != NDESC) begin : g_bad_ndesc
      $error("NDESC must be a power of two between 2 and 16");
   end
   if (AW < 8 || AW > 32) begin : g_bad_aw
      $error("AW must lie between 8 and 32");
   end

   chan_state_e      state_q;
   logic [PTR_W-1:0] idx_q, start_ptr_q;
   logic [AW-1:0]    src_q, dst_q, src_nxt, dst_nxt, tbl_src, tbl_dst;
   logic [CNT_W-1:0] cnt_q, load_cnt, step_cnt;
   logic             sinc_q, dinc_q, swap_q, irq_en_q, last_q;
   logic [LINK_W-1:0] link_q;
   logic [31:0]      data_q, rd_conv;
   desc_ctl_t        tbl_ctl;
   logic             sel_chan, start_wr, clr_wr, fire;

   assign sel_chan = cfg_addr[CA_W-1];
   assign start_wr = cfg_we && sel_chan && (cfg_addr[1:0] == 2'd0);
   assign clr_wr   = cfg_we && sel_chan && (cfg_addr[1:0] == 2'd1);

   dmac_desc_table #(.NDESC(NDESC), .AW(AW)) i_table (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_we && !sel_chan),
      .wr_idx  (cfg_addr[CA_W-2:2]),
      .wr_word (cfg_addr[1:0]),
      .wr_data (cfg_wdata),
      .rd_idx  (idx_q),
      .rd_src  (tbl_src),
      .rd_dst  (tbl_dst),
      .rd_ctl  (tbl_ctl)
   );

   dmac_byte_order #(.DW(32)) i_order (
      .swap (swap_q),
      .din  (mem_rdata),
      .dout (rd_conv)
   );

   dmac_addr_step #(.AW(AW)) i_src_step (
      .addr (src_q), .inc (sinc_q), .wide (swap_q), .next (src_nxt)
   );
   dmac_addr_step #(.AW(AW)) i_dst_step (
      .addr (dst_q), .inc (dinc_q), .wide (swap_q), .next (dst_nxt)
   );

   assign load_cnt = tbl_ctl.swap ? {tbl_ctl.count[CNT_W-1:2], 2'b00} : tbl_ctl.count;
   assign step_cnt = swap_q ? CNT_W'(4) : CNT_W'(1);

   always_comb begin
      fire = 1'b0;
      if (state_q == ST_LOAD_DESC && load_cnt == '0)
         fire = tbl_ctl.irq_en;
      else if (state_q == ST_WRITE && mem_gnt && cnt_q == step_cnt)
         fire = irq_en_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         idx_q       <= '0;
         start_ptr_q <= '0;
         src_q       <= '0;
         dst_q       <= '0;
         cnt_q       <= '0;
         sinc_q      <= 1'b0;
         dinc_q      <= 1'b0;
         swap_q      <= 1'b0;
         irq_en_q    <= 1'b0;
         last_q      <= 1'b0;
         link_q      <= '0;
         data_q      <= '0;
         irq_pulse   <= 1'b0;
         irq_status  <= 1'b0;
      end else begin
         irq_pulse <= fire;
         if (fire)        irq_status <= 1'b1;
         else if (clr_wr) irq_status <= 1'b0;
         if (start_wr)    start_ptr_q <= cfg_wdata[PTR_W-1:0];

         case (state_q)
            ST_IDLE: if (trig) begin
               idx_q   <= start_ptr_q;
               state_q <= ST_LOAD_DESC;
            end
            ST_LOAD_DESC: begin
               src_q    <= tbl_src;
               dst_q    <= tbl_dst;
               cnt_q    <= load_cnt;
               sinc_q   <= tbl_ctl.src_inc;
               dinc_q   <= tbl_ctl.dst_inc;
               swap_q   <= tbl_ctl.swap;
               irq_en_q <= tbl_ctl.irq_en;
               last_q   <= tbl_ctl.last;
               link_q   <= tbl_ctl.link;
               state_q  <= (load_cnt == '0) ? ST_NEXT : ST_READ;
            end
            ST_READ: if (mem_gnt) begin
               data_q  <= rd_conv;
               state_q <= ST_WRITE;
            end
            ST_WRITE: if (mem_gnt) begin
               src_q   <= src_nxt;
               dst_q   <= dst_nxt;
               cnt_q   <= cnt_q - step_cnt;
               state_q <= (cnt_q == step_cnt) ? ST_NEXT : ST_READ;
            end
            ST_NEXT: begin
               if (last_q) state_q <= ST_DONE;
               else begin
                  idx_q   <= link_q[PTR_W-1:0];
                  state_q <= ST_LOAD_DESC;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   wire unused_link = ^link_q;

   assign busy      = (state_q != ST_IDLE);
   assign mem_req   = (state_q == ST_READ) || (state_q == ST_WRITE);
   assign mem_we    = (state_q == ST_WRITE);
   assign mem_word  = swap_q;
   assign mem_addr  = (state_q == ST_WRITE) ? dst_q : src_q;
   assign mem_wdata = data_q;
endmodule

// File: rtl/dmac_chain_engine_chk.sv
module dmac_chain_engine_chk #(
   parameter int AW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          trig,
   input logic          mem_req,
   input logic          mem_we,
   input logic          mem_word,
   input logic [AW-1:0] mem_addr,
   input logic [31:0]   mem_wdata,
   input logic          mem_gnt,
   input logic          busy,
   input logic          irq_pulse,
   input logic          irq_status
);
   a_r9_hold_until_grant: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_gnt |=> mem_req && $stable(mem_we) && $stable(mem_word)
                             && $stable(mem_addr) && $stable(mem_wdata));

   a_r3_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_we && mem_gnt |=> mem_req && mem_we);

   a_r3_no_back_to_back_write: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we && mem_gnt |=> !(mem_req && mem_we));

   a_r6_pulse_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse |=> !irq_pulse);

   a_r7_status_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse |-> irq_status);

   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req && !irq_pulse);

   a_r2_trigger_starts: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && trig |=> busy);
endmodule

bind dmac_chain_engine dmac_chain_engine_chk #(.AW(AW)) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .trig       (trig),
   .mem_req    (mem_req),
   .mem_we     (mem_we),
   .mem_word   (mem_word),
   .mem_addr   (mem_addr),
   .mem_wdata  (mem_wdata),
   .mem_gnt    (mem_gnt),
   .busy       (busy),
   .irq_pulse  (irq_pulse),
   .irq_status (irq_status)
);

// File: tb/test_dmac_chain_engine.sv
`timescale 1ns/1ps
module test_dmac_chain_engine;
   localparam logic [15:0] PERIPH = 16'h0300;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [6:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic        trig = 1'b0;
   logic        mem_req, mem_we, mem_word, busy, irq_pulse, irq_status;
   logic [15:0] mem_addr;
   logic [31:0] mem_wdata, mem_rdata;
   logic        mem_gnt = 1'b0;

   always #5 clk = ~clk;

   dmac_chain_engine i_dmac_chain_engine (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .trig(trig), .mem_req(mem_req), .mem_we(mem_we),
      .mem_word(mem_word), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .busy(busy),
      .irq_pulse(irq_pulse), .irq_status(irq_status)
   );

   // memory and a counting peripheral
   logic [7:0] mem  [1024];
   logic [7:0] mref [1024];
   logic [7:0] pcnt = 8'd0;
   logic [7:0] pmodel = 8'd0;
   logic [9:0] ma;
   assign ma = mem_addr[9:0];
   assign mem_rdata = (mem_addr == PERIPH) ? {24'h0, pcnt} :
                      mem_word ? {mem[ma+10'd3], mem[ma+10'd2], mem[ma+10'd1], mem[ma]} :
                                 {24'h0, mem[ma]};

   function automatic logic [7:0] init_val(input int i);
      return 8'((i * 7 + 3) & 255);
   endfunction

   initial begin
      for (int i = 0; i < 1024; i++) begin
         mem[i]  = init_val(i);
         mref[i] = init_val(i);
      end
   end

   always @(posedge clk) begin
      if (rst_n && mem_req && mem_gnt) begin
         if (mem_we) begin
            if (mem_word)
               for (int k = 0; k < 4; k++) mem[ma + 10'(k)] <= mem_wdata[8*k +: 8];
            else
               mem[ma] <= mem_wdata[7:0];
         end else if (mem_addr == PERIPH) begin
            pcnt <= pcnt + 8'd1;
         end
      end
   end

   // expected event stream: kind 0 = write, 1 = interrupt
   int          ev_kind [$];
   logic [15:0] ev_addr [$];
   logic [31:0] ev_data [$];
   bit          ev_word [$];
   int checks = 0, fails = 0, irq_seen = 0;

   logic [15:0] b_src [16];
   logic [15:0] b_dst [16];
   logic [31:0] b_ctl [16];

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // compared on every clock, away from the edge
   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_req && mem_we && mem_gnt) begin
            if (ev_kind.size() == 0 || ev_kind[0] != 0) begin
               chk(1'b0, "R2", "unexpected write", {16'h0, mem_addr}, 32'h0);
               if (ev_kind.size() != 0) begin
                  void'(ev_kind.pop_front()); void'(ev_addr.pop_front());
                  void'(ev_data.pop_front()); void'(ev_word.pop_front());
               end
            end else begin
               chk(mem_addr == ev_addr[0], "R3", "write address", {16'h0, mem_addr}, {16'h0, ev_addr[0]});
               chk(mem_wdata == ev_data[0], "R5", "write data", mem_wdata, ev_data[0]);
               chk(mem_word == ev_word[0], "R5", "access size", {31'h0, mem_word}, {31'h0, ev_word[0]});
               void'(ev_kind.pop_front()); void'(ev_addr.pop_front());
               void'(ev_data.pop_front()); void'(ev_word.pop_front());
            end
         end
         if (irq_pulse) begin
            irq_seen++;
            chk(ev_kind.size() != 0 && ev_kind[0] == 1, "R6", "interrupt pulse in order",
                32'(ev_kind.size()), 32'h1);
            if (ev_kind.size() != 0) begin
               void'(ev_kind.pop_front()); void'(ev_addr.pop_front());
               void'(ev_data.pop_front()); void'(ev_word.pop_front());
            end
         end
      end
      mem_gnt = ($urandom_range(0, 3) != 0);
   end

   task automatic push_ev(input int k, input logic [15:0] a, input logic [31:0] d, input bit w);
      ev_kind.push_back(k); ev_addr.push_back(a); ev_data.push_back(d); ev_word.push_back(w);
   endtask

   // behavioural reference: walk the chain and list the writes and pulses
   task automatic model_run(input int ptr);
      int idx = ptr;
      for (int g = 0; g < 17; g++) begin
         logic [31:0] c = b_ctl[idx];
         bit sw = c[18];
         int cnt = sw ? (int'(c[15:0]) & ~3) : int'(c[15:0]);
         int step = sw ? 4 : 1;
         logic [15:0] s = b_src[idx];
         logic [15:0] d = b_dst[idx];
         for (int n = 0; n < cnt; n += step) begin
            if (sw) begin
               logic [31:0] wd = {mref[s[9:0]], mref[s[9:0]+10'd1], mref[s[9:0]+10'd2], mref[s[9:0]+10'd3]};
               push_ev(0, d, wd, 1'b1);
               for (int k = 0; k < 4; k++) mref[d[9:0] + 10'(k)] = wd[8*k +: 8];
            end else begin
               logic [7:0] bv;
               if (s == PERIPH) begin bv = pmodel; pmodel = pmodel + 8'd1; end
               else bv = mref[s[9:0]];
               push_ev(0, d, {24'h0, bv}, 1'b0);
               mref[d[9:0]] = bv;
            end
            if (c[16]) s = s + 16'(step);
            if (c[17]) d = d + 16'(step);
         end
         if (c[19]) push_ev(1, 16'h0, 32'h0, 1'b0);
         if (c[20]) break;
         idx = int'(c[27:24]);
      end
   endtask

   task automatic cfg_write(input logic [6:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic set_desc(input int i, input logic [15:0] s, input logic [15:0] d,
                           input logic [31:0] c);
      b_src[i] = s; b_dst[i] = d; b_ctl[i] = c;
      cfg_write({1'b0, 4'(i), 2'd0}, {16'h0, s});
      cfg_write({1'b0, 4'(i), 2'd1}, {16'h0, d});
      cfg_write({1'b0, 4'(i), 2'd2}, c);
   endtask

   function automatic logic [31:0] ctl(input int cnt, input bit si, input bit di, input bit sw,
                                       input bit irq, input bit last, input int link);
      return {4'h0, 4'(link), 3'h0, last, irq, sw, di, si, 16'(cnt)};
   endfunction

   task automatic run_chain(input int ptr);
      cfg_write(7'h40, 32'(ptr));
      model_run(ptr);
      @(negedge clk); trig = 1'b1;
      @(negedge clk); trig = 1'b0;
      while (busy) @(negedge clk);
      repeat (3) @(negedge clk);
      chk(ev_kind.size() == 0, "R4", "events left after chain", 32'(ev_kind.size()), 32'h0);
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      chk(1'b0, "R1", "watchdog expired", 32'h0, 32'h1);
      summary();
      $finish;
   end

   initial begin
      int irq0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(!busy, "R1", "busy after reset", {31'h0, busy}, 32'h0);
      chk(!mem_req, "R1", "req after reset", {31'h0, mem_req}, 32'h0);
      chk(!irq_pulse && !irq_status, "R1", "irq after reset", {30'h0, irq_pulse, irq_status}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // R3/R10: byte copy, both addresses step
      set_desc(0, 16'h0000, 16'h0100, ctl(5, 1, 1, 0, 1, 1, 0));
      run_chain(0);
      chk(mem[10'h104] == init_val(4), "R3", "last copied byte", {24'h0, mem[10'h104]}, {24'h0, init_val(4)});
      chk(mem[10'h105] == init_val(10'h105), "R3", "byte past count", {24'h0, mem[10'h105]}, {24'h0, init_val(10'h105)});
      chk(irq_status, "R7", "status set by completion", {31'h0, irq_status}, 32'h1);

      // R7: clear by channel word 1
      cfg_write(7'h41, 32'h0);
      @(negedge clk);
      chk(!irq_status, "R7", "status cleared", {31'h0, irq_status}, 32'h0);

      // R5: swapped words, count 10 rounds down to 8
      set_desc(1, 16'h0010, 16'h0120, ctl(10, 1, 1, 1, 1, 1, 0));
      run_chain(1);
      chk(mem[10'h120] == init_val(16'h13), "R5", "reversed first byte", {24'h0, mem[10'h120]}, {24'h0, init_val(16'h13)});
      chk(mem[10'h128] == init_val(10'h128), "R5", "truncated tail untouched", {24'h0, mem[10'h128]}, {24'h0, init_val(10'h128)});

      // R4/R6: fixed peripheral source to four buffers, irq on records 5 and 7 only
      irq0 = irq_seen;
      set_desc(4, PERIPH, 16'h0200, ctl(3, 0, 1, 0, 0, 0, 5));
      set_desc(5, PERIPH, 16'h0210, ctl(3, 0, 1, 0, 1, 0, 6));
      set_desc(6, PERIPH, 16'h0220, ctl(3, 0, 1, 0, 0, 0, 7));
      set_desc(7, PERIPH, 16'h0230, ctl(3, 0, 1, 0, 1, 1, 0));
      run_chain(4);
      chk(mem[10'h200] == 8'd0, "R4", "first buffer start", {24'h0, mem[10'h200]}, 32'h0);
      chk(mem[10'h232] == 8'd11, "R4", "fourth buffer end", {24'h0, mem[10'h232]}, 32'd11);
      chk(irq_seen - irq0 == 2, "R6", "pulses from flagged records", 32'(irq_seen - irq0), 32'h2);

      // R8: empty record links on; fixed destination keeps last byte
      irq0 = irq_seen;
      set_desc(8, 16'h0050, 16'h0160, ctl(0, 1, 1, 0, 1, 0, 9));
      set_desc(9, 16'h0020, 16'h0140, ctl(2, 1, 0, 0, 0, 1, 0));
      run_chain(8);
      chk(irq_seen - irq0 == 1, "R8", "empty record interrupts", 32'(irq_seen - irq0), 32'h1);
      chk(mem[10'h160] == init_val(10'h160), "R8", "empty record no write", {24'h0, mem[10'h160]}, {24'h0, init_val(10'h160)});
      chk(mem[10'h140] == init_val(16'h21), "R3", "fixed destination last byte", {24'h0, mem[10'h140]}, {24'h0, init_val(16'h21)});
      chk(mem[10'h141] == init_val(10'h141), "R3", "fixed destination neighbour", {24'h0, mem[10'h141]}, {24'h0, init_val(10'h141)});

      // R2: second trigger while busy is ignored
      cfg_write(7'h40, 32'h0);
      model_run(0);
      @(negedge clk); trig = 1'b1;
      @(negedge clk); trig = 1'b0;
      repeat (2) @(negedge clk);
      chk(busy, "R2", "running before retrigger", {31'h0, busy}, 32'h1);
      trig = 1'b1;
      @(negedge clk); trig = 1'b0;
      while (busy) @(negedge clk);
      repeat (30) @(negedge clk);
      chk(!busy, "R2", "no restart from busy trigger", {31'h0, busy}, 32'h0);
      chk(ev_kind.size() == 0, "R2", "events left", 32'(ev_kind.size()), 32'h0);

      summary();
      $finish;
   end
endmodule